// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block keeps an asynchronous DRAM with a fixed row count alive. After reset it holds the memory quiet for a power-up pause. It then runs a fixed number of wake-up refresh cycles and declares the memory ready. From then on it spreads CAS-before-RAS refresh cycles evenly over the retention period. The device's own internal row counter chooses the row, so the block drives only the three control strobes and never touches the address or data lines.

Each refresh is won through a request/grant handshake with the access arbiter that owns the DRAM pins. A grant that arrives while no request is raised is ignored. Refresh intervals that fall due while a request is still waiting are counted as debt. When the debt reaches its limit, the retention guarantee is treated as lost: a sticky overrun flag is raised, ready status is withdrawn, and the full wake-up burst is replayed.

All timing minimums are given in nanoseconds or microseconds together with the clock frequency. They are rounded up to whole clock cycles at elaboration, so one build serves any speed grade.

Top module: `dram_ref_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, ras_n, cas_n and we_n are high and ref_req, init_done and overrun are low.
- R2: For PAUSE_US*CLK_MHZ cycles after reset is released, ref_req stays low and no strobe moves; the first request appears in the cycle after that count of clock edges.
- R3: Exactly WAKE_CYCLES (default 8) refresh cycles run between the end of the pause and init_done rising. init_done rises in the cycle after the last one's precharge ends.
- R4: A refresh cycle has three phases. First cas_n is low alone for ceil(T_CSR_NS*CLK_MHZ/1000) cycles. Then ras_n and cas_n are both low for the larger of the rounded-up RAS pulse width and CAS hold time. Then both are high for the larger of the rounded-up RAS precharge and RAS-to-CAS precharge. Each rounded value is at least 1.
- R5: we_n is high in every cycle, so it is high before and after every falling edge of ras_n.
- R6: ref_req is high only while no refresh cycle is running. ref_req and ref_gnt both high at a clock edge start a cycle: cas_n falls in the next cycle.
- R7: Once ready, a refresh falls due every floor(RETENTION_US*CLK_MHZ/ROWS) cycles, counted from the cycle in which init_done rises. With an always-granting arbiter, refresh cycles start exactly that many cycles apart.
- R8: In normal operation an owed refresh keeps ref_req high until it is granted. Each interval that falls due while one is already owed adds one to the debt.
- R9: When the debt would reach DEBT_CAP (default 8), overrun goes high and stays high until reset, init_done falls, and WAKE_CYCLES wake-up cycles are replayed before init_done rises again.
- R10: ref_gnt has no effect while ref_req is low. This includes the pause and any running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Arbiter grant for the pending refresh |
| ref_req | output | 1 | Refresh request to the arbiter |
| ras_n | output | 1 | Row strobe, active low, registered |
| cas_n | output | 1 | Column strobe, active low, registered |
| we_n | output | 1 | Write enable, active low, registered (always high) |
| init_done | output | 1 | Memory is initialised and in normal operation |
| overrun | output | 1 | Sticky: the refresh debt limit was reached |

## Verification
The bench builds the block at 50 MHz with a 64-row, 64 µs retention budget and a 2 µs pause. This gives a 50-cycle refresh interval and a 100-cycle pause. At the default slowest-grade timings, each refresh cycle takes 1 lead cycle, 4 low cycles and 3 precharge cycles. These small values bring the pause, both wake-up bursts, steady refresh spacing, a randomly stalling arbiter and a full nine-interval starvation ending in overrun recovery into one short run. The full-size defaults would need a pause of 5000 cycles and intervals of 781 cycles.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    MODE_PAUSE = 2'd0,
    MODE_WAKE  = 2'd1,
    MODE_RUN   = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LEAD = 2'd1,
    SEQ_HOLD = 2'd2,
    SEQ_REST = 2'd3
  } seq_e;

  // Nanoseconds to whole clock cycles, rounded up, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_ref_interval.sv
module dram_ref_interval #(
  parameter int unsigned INT_CYC = 781
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int unsigned IW = (INT_CYC > 2) ? $clog2(INT_CYC) : 1;
  localparam logic [IW-1:0] LAST = IW'(INT_CYC - 1);

  logic [IW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == LAST);

  // Two due intervals never land on neighbouring cycles.
  assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/dram_ref_ledger.sv
module dram_ref_ledger #(
  parameter int unsigned DEBT_CAP = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic take,
  output logic due,
  output logic limit_hit
);
  // Owed refreshes: one waiting request plus up to DEBT_CAP of debt.
  localparam int unsigned OWE_MAX = DEBT_CAP + 1;
  localparam int unsigned OW      = $clog2(OWE_MAX + 1);
  localparam logic [OW:0] CAP_W   = (OW+1)'(DEBT_CAP);

  logic [OW-1:0] owe;
  logic [OW:0]   grow;

  always_comb begin
    grow = {1'b0, owe} + {{OW{1'b0}}, tick} - {{OW{1'b0}}, take};
  end

  assign limit_hit = grow > CAP_W;
  assign due       = (owe != '0);

  always_ff @(posedge clk) begin
    if (rst || clr || limit_hit) begin
      owe <= '0;
    end else begin
      owe <= grow[OW-1:0];
    end
  end

  // A refresh is only taken when one is owed.
  assert_take_needs_due_R8: assert property (@(posedge clk) disable iff (rst)
    take |-> due);

endmodule

// File: rtl/dram_ref_cbr.sv
module dram_ref_cbr
  import dram_ref_pkg::*;
#(
  parameter int unsigned LEAD_CYC = 1,
  parameter int unsigned HOLD_CYC = 4,
  parameter int unsigned REST_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic idle,
  output logic done,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int unsigned CMAX = max_of(max_of(LEAD_CYC, HOLD_CYC), REST_CYC);
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] LEAD_LD = CW'(LEAD_CYC - 1);
  localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] REST_LD = CW'(REST_CYC - 1);

  seq_e          st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SEQ_IDLE;
      cnt   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
    end else begin
      we_n <= 1'b1;
      case (st)
        SEQ_IDLE: begin
          if (start) begin
            st    <= SEQ_LEAD;
            cnt   <= LEAD_LD;
            cas_n <= 1'b0;
          end
        end
        SEQ_LEAD: begin
          if (cnt == '0) begin
            st    <= SEQ_HOLD;
            cnt   <= HOLD_LD;
            ras_n <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SEQ_HOLD: begin
          if (cnt == '0) begin
            st    <= SEQ_REST;
            cnt   <= REST_LD;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            st <= SEQ_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign idle = (st == SEQ_IDLE);
  assign done = (st == SEQ_REST) && (cnt == '0);

  assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
  assert_ras_within_cas_R4: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> !cas_n);
  assert_rest_all_high_R4: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_REST) |-> (ras_n && cas_n));
  assert_we_around_ras_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (we_n && $past(we_n)));

endmodule

// File: rtl/dram_ref_sched.sv
module dram_ref_sched
  import dram_ref_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 50,
  parameter int unsigned ROWS         = 2048,
  parameter int unsigned RETENTION_US = 32000,
  parameter int unsigned PAUSE_US     = 100,
  parameter int unsigned WAKE_CYCLES  = 8,
  parameter int unsigned DEBT_CAP     = 8,
  parameter int unsigned T_CSR_NS     = 10,
  parameter int unsigned T_CHR_NS     = 15,
  parameter int unsigned T_RAS_NS     = 80,
  parameter int unsigned T_RP_NS      = 60,
  parameter int unsigned T_RPC_NS     = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic init_done,
  output logic overrun
);
  localparam int unsigned INT_CYC   = (RETENTION_US * CLK_MHZ) / ROWS;
  localparam int unsigned PAUSE_CYC = PAUSE_US * CLK_MHZ;
  localparam int unsigned LEAD_CYC  = ns_to_cycles(T_CSR_NS, CLK_MHZ);
  localparam int unsigned HOLD_CYC  = max_of(ns_to_cycles(T_RAS_NS, CLK_MHZ),
                                             ns_to_cycles(T_CHR_NS, CLK_MHZ));
  localparam int unsigned REST_CYC  = max_of(ns_to_cycles(T_RP_NS, CLK_MHZ),
                                             ns_to_cycles(T_RPC_NS, CLK_MHZ));
  localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
  localparam int unsigned WW = $clog2(WAKE_CYCLES + 1);
  localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [WW-1:0] WAKE_ALL   = WW'(WAKE_CYCLES);

  mode_e         mode;
  logic [PW-1:0] pcnt;
  logic [WW-1:0] wcnt;
  logic          seq_idle, seq_done, tick, due, limit_hit;
  logic          wake_want, acc;

  assign wake_want = (mode == MODE_WAKE) && (wcnt != WAKE_ALL);
  assign ref_req   = seq_idle && (wake_want || ((mode == MODE_RUN) && due));
  assign acc       = ref_req && ref_gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= MODE_PAUSE;
      pcnt      <= '0;
      wcnt      <= '0;
      init_done <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      case (mode)
        MODE_PAUSE: begin
          if (pcnt == PAUSE_LAST) begin
            mode <= MODE_WAKE;
            wcnt <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        MODE_WAKE: begin
          if (acc) begin
            wcnt <= wcnt + 1'b1;
          end
          if (seq_done && (wcnt == WAKE_ALL)) begin
            mode      <= MODE_RUN;
            init_done <= 1'b1;
          end
        end
        default: begin
          if (limit_hit) begin
            mode      <= MODE_WAKE;
            wcnt      <= '0;
            overrun   <= 1'b1;
            init_done <= 1'b0;
          end
        end
      endcase
    end
  end

  dram_ref_interval #(.INT_CYC(INT_CYC)) u_interval (
    .clk  (clk),
    .rst  (rst),
    .en   (mode == MODE_RUN),
    .tick (tick)
  );

  dram_ref_ledger #(.DEBT_CAP(DEBT_CAP)) u_ledger (
    .clk       (clk),
    .rst       (rst),
    .clr       (mode != MODE_RUN),
    .tick      (tick),
    .take      (acc && (mode == MODE_RUN)),
    .due       (due),
    .limit_hit (limit_hit)
  );

  dram_ref_cbr #(
    .LEAD_CYC (LEAD_CYC),
    .HOLD_CYC (HOLD_CYC),
    .REST_CYC (REST_CYC)
  ) u_cbr (
    .clk   (clk),
    .rst   (rst),
    .start (acc),
    .idle  (seq_idle),
    .done  (seq_done),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n)
  );

  assert_quiet_pause_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PAUSE) |-> (!ref_req && ras_n && cas_n));
  assert_ready_after_rest_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (ras_n && cas_n));
  assert_req_held_R8: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_gnt && (mode == MODE_RUN) && !limit_hit) |=> ref_req);
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  assert_grant_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (seq_idle && !ref_req) |=> cas_n);

endmodule

// File: tb/dram_ref_sched_tb.sv
`timescale 1ns/1ps
module dram_ref_sched_tb;
  localparam int MHZ = 50, ROWS = 64, RET_US = 64, PAUSE_US = 2;
  localparam int WAKE = 8, CAP = 8;
  localparam int INTV   = (RET_US * MHZ) / ROWS;   // 50
  localparam int PAUSEC = PAUSE_US * MHZ;          // 100
  localparam int LEADC  = 1;                       // ceil(10ns*50MHz)
  localparam int HOLDC  = 4;                       // ceil(80ns), > ceil(15ns)
  localparam int RESTC  = 3;                       // ceil(60ns), > ceil(5ns)

  logic clk = 0, rst = 1, ref_gnt = 0;
  logic ref_req, ras_n, cas_n, we_n, init_done, overrun;
  int checks = 0, fails = 0, cyc = 0, wd = 0;

  always #10 clk = ~clk;

  dram_ref_sched #(.CLK_MHZ(MHZ), .ROWS(ROWS), .RETENTION_US(RET_US), .PAUSE_US(PAUSE_US))
  u_dut (.clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req), .ras_n(ras_n),
         .cas_n(cas_n), .we_n(we_n), .init_done(init_done), .overrun(overrun));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
    end
  endtask

  // ---- behavioural reference model ----
  int m_mode = 0, m_pause = 0, m_iss = 0, m_owe = 0, m_ph = 0;
  bit m_over = 0, m_show = 0;
  bit [1:0] m_pins = 2'b11;   // {ras_n, cas_n}
  bit [1:0] pq[$];

  function automatic bit m_req();
    return !m_show && ((m_mode == 1 && m_iss < WAKE) || (m_mode == 2 && m_owe > 0));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_pause = 0; m_iss = 0; m_owe = 0; m_ph = 0;
      m_over = 0; m_show = 0; m_pins = 2'b11; pq.delete(); cyc = 0;
    end else begin
      bit acc, fin, tk;
      int nxt;
      cyc++;
      acc = m_req() && ref_gnt;
      fin = m_show && (pq.size() == 0);
      tk  = (m_mode == 2) && (m_ph == INTV - 1);
      case (m_mode)
        0: if (m_pause == PAUSEC - 1) begin m_mode = 1; m_iss = 0; end else m_pause++;
        1: begin
             if (fin && m_iss == WAKE) begin m_mode = 2; m_owe = 0; m_ph = 0; end
             if (acc) m_iss++;
           end
        default: begin
             m_ph = tk ? 0 : m_ph + 1;
             nxt = m_owe + int'(tk) - int'(acc);
             if (nxt > CAP) begin m_over = 1; m_mode = 1; m_iss = 0; m_owe = 0; m_ph = 0; end
             else m_owe = nxt;
           end
      endcase
      if (acc) begin
        for (int i = 0; i < LEADC; i++) pq.push_back(2'b10);
        for (int i = 0; i < HOLDC; i++) pq.push_back(2'b00);
        for (int i = 0; i < RESTC; i++) pq.push_back(2'b11);
      end
      if (pq.size() > 0) begin m_pins = pq.pop_front(); m_show = 1; end
      else begin m_pins = 2'b11; m_show = 0; end
    end
  end

  // ---- per-cycle comparison and event log, sampled mid-cycle ----
  string phase_tag = "R6";
  bit prev_cas = 1, prev_ras = 1, prev_done = 0, prev_over = 0, seen_req = 0;
  int first_req = -1, over_at = -1;
  int cas_fall[$], ras_fall[$], ras_rise[$], done_rise[$];

  always @(negedge clk) begin
    if (!rst) begin
      chk(ras_n == m_pins[1], "R4", "ras_n", ras_n, m_pins[1]);
      chk(cas_n == m_pins[0], "R4", "cas_n", cas_n, m_pins[0]);
      chk(we_n == 1'b1, "R5", "we_n", we_n, 1);
      chk(ref_req == m_req(), {phase_tag, " R8"}, "ref_req", ref_req, m_req());
      chk(init_done == (m_mode == 2), "R3", "init_done", init_done, m_mode == 2);
      chk(overrun == m_over, "R9", "overrun", overrun, m_over);
      if (ref_req && !seen_req) begin seen_req = 1; first_req = cyc; end
      if (prev_cas && !cas_n) cas_fall.push_back(cyc);
      if (prev_ras && !ras_n) ras_fall.push_back(cyc);
      if (!prev_ras && ras_n) ras_rise.push_back(cyc);
      if (!prev_done && init_done) done_rise.push_back(cyc);
      if (!prev_over && overrun) over_at = cyc;
      prev_cas = cas_n; prev_ras = ras_n; prev_done = init_done; prev_over = overrun;
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual %0d expected below 20000 cycles", wd);
      summary();
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  function automatic int falls_between(input int a, input int b);
    int n = 0;
    foreach (cas_fall[i]) if (cas_fall[i] > a && cas_fall[i] < b) n++;
    return n;
  endfunction

  int lfsr = 32'h1d2c3b4a;

  initial begin
    step(4);
    @(negedge clk);
    // R1: reset values
    chk(ras_n && cas_n && we_n, "R1", "strobes in reset", {ras_n, cas_n, we_n}, 7);
    chk(!ref_req && !init_done && !overrun, "R1", "flags in reset",
        {ref_req, init_done, overrun}, 0);
    @(posedge clk); #2;
    rst = 0;
    phase_tag = "R10";
    ref_gnt = 1;                    // grant held during the pause: must be ignored (R10)
    step(1);
    @(negedge clk);
    chk(ras_n && cas_n && !ref_req && !init_done, "R1", "first cycle after reset",
        {ras_n, cas_n, ref_req, init_done}, 12);
    step(400);                      // pause, wake burst, steady refresh with instant grants
    phase_tag = "R6";
    for (int k = 0; k < 400; k++) begin  // stalling arbiter (R8)
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ref_gnt = (lfsr[1:0] == 2'b00);
      step(1);
    end
    phase_tag = "R8";
    ref_gnt = 0;                    // starve the block until the debt limit (R9)
    step(600);
    phase_tag = "R6";
    ref_gnt = 1;                    // recovery burst
    step(300);
    @(negedge clk);

    chk(first_req == PAUSEC, "R2", "first request cycle", first_req, PAUSEC);
    chk(done_rise.size() >= 1 && falls_between(0, done_rise[0]) == WAKE, "R3",
        "wake cycles before ready", falls_between(0, done_rise[0]), WAKE);
    chk(ras_fall[0] - cas_fall[0] == LEADC, "R4", "cas lead", ras_fall[0] - cas_fall[0], LEADC);
    chk(ras_rise[0] - ras_fall[0] == HOLDC, "R4", "ras low width", ras_rise[0] - ras_fall[0], HOLDC);
    chk(cas_fall[1] - ras_rise[0] == RESTC + 1, "R4", "precharge gap",
        cas_fall[1] - ras_rise[0], RESTC + 1);
    begin
      int a = -1, b = -1;
      foreach (cas_fall[i]) if (cas_fall[i] > done_rise[0]) begin
        if (a < 0) a = cas_fall[i]; else if (b < 0) b = cas_fall[i];
      end
      chk(a - done_rise[0] == INTV + 1, "R7", "first refresh after ready", a - done_rise[0], INTV + 1);
      chk(b - a == INTV, "R7", "refresh spacing", b - a, INTV);
    end
    chk(overrun == 1'b1 && over_at > 0, "R9", "overrun raised", overrun, 1);
    chk(done_rise.size() == 2, "R9", "ready twice", done_rise.size(), 2);
    if (done_rise.size() == 2)
      chk(falls_between(over_at, done_rise[1]) == WAKE, "R9", "replayed wake cycles",
          falls_between(over_at, done_rise[1]), WAKE);
    summary();
  end
endmodule